// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural registers of a 32-bit processor that runs in several privilege modes. The datapath sees sixteen general registers, one current status word and one saved status word. Some of the general registers, and the saved status word, exist once per mode. The mode currently in effect decides which physical copy a logical index reaches.

The datapath has two combinational read ports and one synchronous write port. A separate exception sequencer drives a mode-change strobe with a target mode. It may also ask for the current status word to be captured into the target mode's saved status.

Banking is done with a fixed physical array and an index map, so a mode change takes effect on the next cycle without any copy cycles. An unsupported target mode is rejected and leaves everything as it was.

Top module: `modal_regfile`

## Requirements
- R1: After a synchronous active-low reset the mode is 0x1F and the status word reads 0x0000001F. The shared stack register (R13) holds 0x03007F00, the interrupt-mode R13 holds 0x03007FA0 and the supervisor-mode R13 holds 0x03007FE0. Every other general register and every saved status word is zero.
- R2: Logical registers R0 to R7 and R15 map to the same physical register in every mode.
- R3: In fast-interrupt mode (0x11), R8 to R14 are private copies. After leaving that mode, R8 to R12 again show the values shared by the other modes, and the private values persist for the next visit.
- R4: Interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes each bank only R13 and R14. In these modes R8 to R12 are the shared copies.
- R5: User (0x10) and system (0x1F) modes use one common R13/R14 pair. In those two modes the saved status reads zero, and a saved-status write has no effect on any mode's saved status.
- R6: A mode change with capture into a mode that has a saved status loads that saved status with the status word as it was before the change, old mode bits included.
- R7: A mode change without capture presents the saved status last stored for the target mode.
- R8: The legal mode codes are 0x10, 0x11, 0x12, 0x13, 0x17, 0x1B and 0x1F. A mode change to any other code leaves the mode, the status word, the saved status words and the general registers unchanged.
- R9: A general-register write in the same cycle as a mode change is addressed using the mode in effect before the change.
- R10: Bits 4:0 of the status word always equal the current mode. A status write updates only bits 31:5.
- R11: Both read ports return register contents combinationally and independently. A write becomes visible after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General-register write enable |
| wr_idx | input | 4 | Logical index of the write |
| wr_data | input | 32 | Write data |
| stat_wr_en | input | 1 | Status word write enable (bits 31:5) |
| stat_wr_data | input | 32 | Status word write data |
| saved_wr_en | input | 1 | Saved status write enable (current mode's copy) |
| saved_wr_data | input | 32 | Saved status write data |
| mode_chg | input | 1 | Mode-change strobe |
| mode_new | input | 5 | Target mode code |
| mode_capture | input | 1 | Capture status into target saved status |
| cur_mode | output | 5 | Mode in effect |
| cur_status | output | 32 | Current status word |
| saved_status | output | 32 | Saved status of the current mode, zero in user/system |

## Verification
Assertions check on every cycle that the mode register only ever holds a legal code and that a rejected mode change leaves it stable. They also check that a capture lands the prior status word, that a change without capture shows the stored copy, and that each write reaches the slot picked under the old mode while all other physical slots hold still. Only the bench's scenarios can show the visible aliasing: which logical index reaches which copy in each mode, the reset values seen through the ports, and that shared R8 to R12 values come back after the fast-interrupt mode is left. The same applies to the shared user/system pair and to the ordering of a write and a mode change in the same cycle, both of which the bench observes through the read ports.

// File: rtl/modal_regfile_pkg.sv
// Package: modal_regfile_pkg
// Shared constants and helpers for the mode-banked register file: mode codes,
// physical slot layout and the mode-to-bank lookups.
// Assumes 5-bit mode codes and 16 logical general registers.
package modal_regfile_pkg;

    localparam int MODE_W      = 5;
    localparam int LOG_IDX_W   = 4;
    localparam int NUM_PHYS    = 31;
    localparam int PHYS_IDX_W  = $clog2(NUM_PHYS);
    localparam int NUM_SAVED   = 5;
    localparam int SAVED_IDX_W = $clog2(NUM_SAVED);

    localparam logic [MODE_W-1:0] MD_USER = 5'h10;
    localparam logic [MODE_W-1:0] MD_FAST = 5'h11;
    localparam logic [MODE_W-1:0] MD_IRQ  = 5'h12;
    localparam logic [MODE_W-1:0] MD_SUPV = 5'h13;
    localparam logic [MODE_W-1:0] MD_ABRT = 5'h17;
    localparam logic [MODE_W-1:0] MD_UNDF = 5'h1B;
    localparam logic [MODE_W-1:0] MD_SYS  = 5'h1F;

    // Physical layout: 0..15 shared set, 16..22 fast-mode R8..R14,
    // then one R13/R14 pair for each of irq, supervisor, abort, undefined.
    localparam int SLOT_FAST_R8  = 16;
    localparam int SLOT_IRQ_SP   = 23;
    localparam int SLOT_SUPV_SP  = 25;
    localparam int SLOT_ABRT_SP  = 27;
    localparam int SLOT_UNDF_SP  = 29;
    localparam int SLOT_SHARE_SP = 13;

    // True for the seven supported mode codes.
    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return (m == MD_USER) || (m == MD_FAST) || (m == MD_IRQ) ||
               (m == MD_SUPV) || (m == MD_ABRT) || (m == MD_UNDF) ||
               (m == MD_SYS);
    endfunction

    // True for modes that own a saved status word.
    function automatic logic mode_has_saved(input logic [MODE_W-1:0] m);
        return mode_legal(m) && (m != MD_USER) && (m != MD_SYS);
    endfunction

    // Saved-status slot of a mode (only meaningful when mode_has_saved).
    function automatic logic [SAVED_IDX_W-1:0] saved_slot(input logic [MODE_W-1:0] m);
        logic [SAVED_IDX_W-1:0] s;
        case (m)
            MD_FAST: s = 3'd0;
            MD_IRQ:  s = 3'd1;
            MD_SUPV: s = 3'd2;
            MD_ABRT: s = 3'd3;
            MD_UNDF: s = 3'd4;
            default: s = 3'd0;
        endcase
        return s;
    endfunction

    // First physical slot of the banked R13/R14 pair for a non-fast mode.
    function automatic logic [PHYS_IDX_W-1:0] sp_base(input logic [MODE_W-1:0] m);
        logic [PHYS_IDX_W-1:0] b;
        case (m)
            MD_IRQ:  b = PHYS_IDX_W'(SLOT_IRQ_SP);
            MD_SUPV: b = PHYS_IDX_W'(SLOT_SUPV_SP);
            MD_ABRT: b = PHYS_IDX_W'(SLOT_ABRT_SP);
            MD_UNDF: b = PHYS_IDX_W'(SLOT_UNDF_SP);
            default: b = PHYS_IDX_W'(SLOT_SHARE_SP);
        endcase
        return b;
    endfunction

endpackage

// File: rtl/modal_slot_map.sv
// Module: modal_slot_map
// Combinational translation of (mode, logical index) to a physical slot.
// Assumes the mode is legal; unknown codes fall back to the shared set.
module modal_slot_map
    import modal_regfile_pkg::*;
(
    input  logic [MODE_W-1:0]     mode,
    input  logic [LOG_IDX_W-1:0]  log_idx,
    output logic [PHYS_IDX_W-1:0] phys_idx
);

    localparam logic [LOG_IDX_W-1:0] IDX_R8  = 4'd8;
    localparam logic [LOG_IDX_W-1:0] IDX_R13 = 4'd13;
    localparam logic [LOG_IDX_W-1:0] IDX_R14 = 4'd14;

    // Pick the private copy when the mode banks this index, else the shared one.
    always_comb begin
        phys_idx = PHYS_IDX_W'(log_idx);
        if (mode == MD_FAST && log_idx >= IDX_R8 && log_idx <= IDX_R14) begin
            phys_idx = PHYS_IDX_W'(SLOT_FAST_R8) + PHYS_IDX_W'(log_idx - IDX_R8);
        end else if (log_idx == IDX_R13 || log_idx == IDX_R14) begin
            phys_idx = sp_base(mode) + PHYS_IDX_W'(log_idx - IDX_R13);
        end
    end

endmodule

// File: rtl/modal_gpr_bank.sv
// Module: modal_gpr_bank
// Physical general-register array of NUM_PHYS words with two combinational
// read ports and one synchronous write port, all addressed by physical slot.
// Assumes slot indices come from modal_slot_map and are in range.
module modal_gpr_bank
    import modal_regfile_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] RST_SP_SHR = 32'h0300_7F00,
    parameter logic [DATA_W-1:0] RST_SP_IRQ = 32'h0300_7FA0,
    parameter logic [DATA_W-1:0] RST_SP_SUP = 32'h0300_7FE0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PHYS_IDX_W-1:0] rd_a_slot,
    output logic [DATA_W-1:0]     rd_a_word,
    input  logic [PHYS_IDX_W-1:0] rd_b_slot,
    output logic [DATA_W-1:0]     rd_b_word,
    input  logic                  wr_en,
    input  logic [PHYS_IDX_W-1:0] wr_slot,
    input  logic [DATA_W-1:0]     wr_word
);

    logic [DATA_W-1:0] rf [NUM_PHYS];

    // Reset value of a physical slot: three stack registers are preset.
    function automatic logic [DATA_W-1:0] reset_val(input int s);
        if (s == SLOT_SHARE_SP) return RST_SP_SHR;
        if (s == SLOT_IRQ_SP)   return RST_SP_IRQ;
        if (s == SLOT_SUPV_SP)  return RST_SP_SUP;
        return '0;
    endfunction

    // Storage update: reset presets, otherwise one slot written per cycle.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_PHYS; s++) begin
            if (!rst_n) begin
                rf[s] <= reset_val(s);
            end else if (wr_en && wr_slot == PHYS_IDX_W'(s)) begin
                rf[s] <= wr_word;
            end
        end
    end

    // Read ports: independent combinational lookups.
    assign rd_a_word = rf[rd_a_slot];
    assign rd_b_word = rf[rd_b_slot];

    // R9/R11: the written word lands in the slot chosen in the write cycle.
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rf[$past(wr_slot)] == $past(wr_word));

    // R8: slots not targeted by a write keep their value.
    generate
        for (genvar g = 0; g < NUM_PHYS; g++) begin : g_hold
            p_slot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_slot == PHYS_IDX_W'(g)) |=> $stable(rf[g]));
        end
    endgenerate

endmodule

// File: rtl/modal_psr_bank.sv
// Module: modal_psr_bank
// Holds the mode, the status word and the banked saved status words.
// Handles the mode-change strobe, including optional capture and rejection
// of unsupported codes. Assumes at most one mode change per cycle.
module modal_psr_bank
    import modal_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_chg,
    input  logic [MODE_W-1:0] mode_new,
    input  logic              mode_capture,
    input  logic              stat_wr_en,
    input  logic [DATA_W-1:0] stat_wr_data,
    input  logic              saved_wr_en,
    input  logic [DATA_W-1:0] saved_wr_data,
    output logic [MODE_W-1:0] cur_mode,
    output logic [DATA_W-1:0] cur_status,
    output logic [DATA_W-1:0] saved_status
);

    localparam int HI_W = DATA_W - MODE_W;

    logic [MODE_W-1:0] mode_q;
    logic [HI_W-1:0]   stat_hi_q;
    logic [DATA_W-1:0] saved_q [NUM_SAVED];
    logic              chg_ok;
    logic              cap_ok;
    logic              sw_ok;

    assign chg_ok     = mode_chg && mode_legal(mode_new);
    assign cap_ok     = chg_ok && mode_capture && mode_has_saved(mode_new);
    assign sw_ok      = saved_wr_en && mode_has_saved(mode_q);
    assign cur_mode   = mode_q;
    assign cur_status = {stat_hi_q, mode_q};

    // Mode register: follows accepted mode changes only.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= MD_SYS;
        else if (chg_ok) mode_q <= mode_new;
    end

    // Status word upper bits: written directly by the datapath.
    always_ff @(posedge clk) begin
        if (!rst_n)          stat_hi_q <= '0;
        else if (stat_wr_en) stat_hi_q <= stat_wr_data[DATA_W-1:MODE_W];
    end

    // Saved status words: capture into target mode wins over a plain write.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SAVED; s++) begin
            if (!rst_n) begin
                saved_q[s] <= '0;
            end else if (cap_ok && saved_slot(mode_new) == SAVED_IDX_W'(s)) begin
                saved_q[s] <= cur_status;
            end else if (sw_ok && saved_slot(mode_q) == SAVED_IDX_W'(s)) begin
                saved_q[s] <= saved_wr_data;
            end
        end
    end

    // Saved status view: the current mode's copy, zero where none exists.
    always_comb begin
        saved_status = '0;
        if (mode_has_saved(mode_q)) saved_status = saved_q[saved_slot(mode_q)];
    end

    // R8: the mode register never holds an unsupported code.
    p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_legal(mode_q));

    // R8: a rejected change leaves mode and status untouched.
    p_bad_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && !mode_legal(mode_new) && !stat_wr_en) |=>
            ($stable(mode_q) && $stable(cur_status)));

    // R6: capture presents the pre-change status word in the new mode.
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ok |=> saved_status == $past(cur_status));

    // R7: without capture the stored copy of the target mode is shown.
    p_no_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_ok && !mode_capture && mode_has_saved(mode_new) && !saved_wr_en) |=>
            saved_status == $past(saved_q[saved_slot(mode_new)]));

endmodule

// File: rtl/modal_regfile.sv
// Module: modal_regfile
// Top of the mode-banked register file. Maps logical indices through the
// current mode to physical slots for both reads and the write, so a write in
// a mode-change cycle uses the old mode. Assumes an external sequencer
// drives mode changes; no decode or ALU lives here.
module modal_regfile
    import modal_regfile_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] RST_SP_SHR = 32'h0300_7F00,
    parameter logic [DATA_W-1:0] RST_SP_IRQ = 32'h0300_7FA0,
    parameter logic [DATA_W-1:0] RST_SP_SUP = 32'h0300_7FE0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LOG_IDX_W-1:0] rd_a_idx,
    output logic [DATA_W-1:0]    rd_a_data,
    input  logic [LOG_IDX_W-1:0] rd_b_idx,
    output logic [DATA_W-1:0]    rd_b_data,
    input  logic                 wr_en,
    input  logic [LOG_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 stat_wr_en,
    input  logic [DATA_W-1:0]    stat_wr_data,
    input  logic                 saved_wr_en,
    input  logic [DATA_W-1:0]    saved_wr_data,
    input  logic                 mode_chg,
    input  logic [MODE_W-1:0]    mode_new,
    input  logic                 mode_capture,
    output logic [MODE_W-1:0]    cur_mode,
    output logic [DATA_W-1:0]    cur_status,
    output logic [DATA_W-1:0]    saved_status
);

    localparam int NUM_PORTS = 3;

    logic [MODE_W-1:0]     mode_now;
    logic [LOG_IDX_W-1:0]  port_idx  [NUM_PORTS];
    logic [PHYS_IDX_W-1:0] port_slot [NUM_PORTS];

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;
    assign cur_mode    = mode_now;

    modal_psr_bank #(.DATA_W(DATA_W)) u_psr (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_chg      (mode_chg),
        .mode_new      (mode_new),
        .mode_capture  (mode_capture),
        .stat_wr_en    (stat_wr_en),
        .stat_wr_data  (stat_wr_data),
        .saved_wr_en   (saved_wr_en),
        .saved_wr_data (saved_wr_data),
        .cur_mode      (mode_now),
        .cur_status    (cur_status),
        .saved_status  (saved_status)
    );

    // One slot map per access port, all driven by the mode before any change.
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
            modal_slot_map u_map (
                .mode     (mode_now),
                .log_idx  (port_idx[p]),
                .phys_idx (port_slot[p])
            );
        end
    endgenerate

    modal_gpr_bank #(
        .DATA_W     (DATA_W),
        .RST_SP_SHR (RST_SP_SHR),
        .RST_SP_IRQ (RST_SP_IRQ),
        .RST_SP_SUP (RST_SP_SUP)
    ) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_slot (port_slot[0]),
        .rd_a_word (rd_a_data),
        .rd_b_slot (port_slot[1]),
        .rd_b_word (rd_b_data),
        .wr_en     (wr_en),
        .wr_slot   (port_slot[2]),
        .wr_word   (wr_data)
    );

endmodule

// File: tb/modal_regfile_test.sv
`timescale 1ns/1ps
module modal_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, stat_wr_en = 1'b0, saved_wr_en = 1'b0;
    logic [31:0] stat_wr_data = '0, saved_wr_data = '0;
    logic        mode_chg = 1'b0, mode_capture = 1'b0;
    logic [4:0]  mode_new = '0, cur_mode;
    logic [31:0] cur_status, saved_status;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    modal_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data),
        .mode_chg(mode_chg), .mode_new(mode_new), .mode_capture(mode_capture),
        .cur_mode(cur_mode), .cur_status(cur_status), .saved_status(saved_status)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] val);
        rd_a_idx = idx;
        #1;
        val = rd_a_data;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic go(input logic [4:0] m, input logic cap);
        mode_chg = 1'b1; mode_new = m; mode_capture = cap;
        tick();
        mode_chg = 1'b0; mode_capture = 1'b0;
    endtask

    task automatic set_status(input logic [31:0] d);
        stat_wr_en = 1'b1; stat_wr_data = d;
        tick();
        stat_wr_en = 1'b0;
    endtask

    task automatic set_saved(input logic [31:0] d);
        saved_wr_en = 1'b1; saved_wr_data = d;
        tick();
        saved_wr_en = 1'b0;
    endtask

    // R1: reset contents seen through the ports
    task automatic t_reset();
        logic [31:0] v;
        check("R1 mode", {27'd0, cur_mode}, 32'h1F);
        check("R1 status", cur_status, 32'h0000_001F);
        check("R1 saved", saved_status, 32'h0);
        rd(4'd13, v); check("R1 shared R13", v, 32'h0300_7F00);
        rd(4'd0, v);  check("R1 R0", v, 32'h0);
        go(5'h12, 1'b0);
        rd(4'd13, v); check("R1 irq R13", v, 32'h0300_7FA0);
        check("R1 irq saved", saved_status, 32'h0);
        go(5'h13, 1'b0);
        rd(4'd13, v); check("R1 supv R13", v, 32'h0300_7FE0);
        go(5'h11, 1'b0);
        rd(4'd13, v); check("R1 fast R13", v, 32'h0);
        go(5'h1F, 1'b0);
    endtask

    // R2/R3/R11: shared low registers, fast-mode private R8..R14
    task automatic t_fast();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) wr(4'(i), 32'h100 + 32'(i));
        rd_a_idx = 4'd0; rd_b_idx = 4'd15; #1;
        check("R11 port A", rd_a_data, 32'h100);
        check("R11 port B", rd_b_data, 32'h10F);
        go(5'h11, 1'b0);
        rd(4'd0, v);  check("R2 fast R0", v, 32'h100);
        rd(4'd7, v);  check("R2 fast R7", v, 32'h107);
        rd(4'd15, v); check("R2 fast R15", v, 32'h10F);
        rd(4'd8, v);  check("R3 fast R8 private", v, 32'h0);
        rd(4'd14, v); check("R3 fast R14 private", v, 32'h0);
        wr(4'd8, 32'hF8);
        rd(4'd8, v);  check("R11 fast R8 after write", v, 32'hF8);
        go(5'h1F, 1'b0);
        rd(4'd8, v);  check("R3 shared R8 restored", v, 32'h108);
        rd(4'd12, v); check("R3 shared R12 restored", v, 32'h10C);
        go(5'h11, 1'b0);
        rd(4'd8, v);  check("R3 fast R8 kept", v, 32'hF8);
        go(5'h1F, 1'b0);
    endtask

    // R4/R5: interrupt-class banking and shared user/system pair
    task automatic t_irq_user();
        logic [31:0] v;
        go(5'h12, 1'b0);
        rd(4'd8, v);  check("R4 irq R8 shared", v, 32'h108);
        rd(4'd13, v); check("R4 irq R13 banked", v, 32'h0300_7FA0);
        wr(4'd13, 32'hA13);
        wr(4'd12, 32'hC12);
        go(5'h1F, 1'b0);
        rd(4'd13, v); check("R4 sys R13 untouched", v, 32'h10D);
        rd(4'd12, v); check("R4 R12 write shared", v, 32'hC12);
        go(5'h10, 1'b0);
        rd(4'd13, v); check("R5 user R13 = sys R13", v, 32'h10D);
        wr(4'd14, 32'h514);
        check("R5 user saved zero", saved_status, 32'h0);
        go(5'h1F, 1'b0);
        rd(4'd14, v); check("R5 sys R14 = user R14", v, 32'h514);
    endtask

    // R6/R7/R10/R5: capture, no-capture, status low bits
    task automatic t_capture();
        go(5'h10, 1'b0);
        set_status(32'hA000_001F);
        check("R10 low bits keep mode", cur_status, 32'hA000_0010);
        go(5'h13, 1'b1);
        check("R6 supv capture", saved_status, 32'hA000_0010);
        check("R10 status follows mode", cur_status, 32'hA000_0013);
        set_status(32'h5000_0000);
        go(5'h17, 1'b1);
        check("R6 abort capture", saved_status, 32'h5000_0013);
        go(5'h13, 1'b0);
        check("R7 supv kept", saved_status, 32'hA000_0010);
        set_saved(32'h1234);
        check("R7 supv written", saved_status, 32'h1234);
        go(5'h1B, 1'b0);
        check("R7 undef untouched", saved_status, 32'h0);
        go(5'h10, 1'b0);
        set_saved(32'hDEAD);
        check("R5 user saved still zero", saved_status, 32'h0);
        go(5'h13, 1'b0);
        check("R5 user write ignored", saved_status, 32'h1234);
    endtask

    // R8: unsupported code changes nothing
    task automatic t_bad_mode();
        logic [31:0] v;
        go(5'h15, 1'b1);
        check("R8 mode held", {27'd0, cur_mode}, 32'h13);
        check("R8 status held", cur_status, 32'h5000_0013);
        check("R8 saved held", saved_status, 32'h1234);
        rd(4'd13, v); check("R8 R13 held", v, 32'h0300_7FE0);
        go(5'h00, 1'b0);
        check("R8 zero code rejected", {27'd0, cur_mode}, 32'h13);
    endtask

    // R9: write in a mode-change cycle uses the old mode
    task automatic t_same_cycle();
        logic [31:0] v;
        go(5'h1F, 1'b0);
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hBEEF;
        mode_chg = 1'b1; mode_new = 5'h12; mode_capture = 1'b0;
        tick();
        wr_en = 1'b0; mode_chg = 1'b0;
        check("R9 mode switched", {27'd0, cur_mode}, 32'h12);
        rd(4'd13, v); check("R9 irq R13 not hit", v, 32'hA13);
        go(5'h1F, 1'b0);
        rd(4'd13, v); check("R9 sys R13 written", v, 32'hBEEF);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_fast();
        t_irq_user();
        t_capture();
        t_bad_mode();
        t_same_cycle();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule